// File: doc/BRIEF.md
# Programmable Chip-Select Channel

This block drives one active-low chip-select line for a 16-bit asynchronous external bus. A single option word sets when the line may assert: which byte lanes, which transfer direction, which address space, and (for CPU-space interrupt-acknowledge cycles) which interrupt level. It also sets the timing source for the assertion and how the cycle is acknowledged. Base-address decoding happens elsewhere and reaches the channel as a single hit input.

When a bus cycle matches, the chip-select asserts on the clock edge where the chosen strobe is seen low. That strobe is the address strobe or the data strobe, or, in synchronous mode, a one-cycle pulse that marks the slow bus clock. After that edge an internal acknowledge (or an autovector request) pulses for one cycle, once a programmed number of wait states has passed. Fast termination skips the wait, and the external setting leaves the acknowledge to the device. All outputs release on the edge after the address strobe negates. An instance built as the boot channel comes out of reset with an option word that already lets it respond.

Top module: `cs_channel`

## Requirements
- R1: The 16-bit option word loads from `cfgData` on a clock edge with `cfgWe` high. Its bit positions are: [15] sync mode, [14:13] lane select, [12:11] direction select, [10] data-strobe timing, [9:6] acknowledge code, [5:4] space select, [3:1] interrupt level, [0] autovector.
- R2: Lane select 00 never asserts. With `portWide` low, any nonzero lane select allows assertion. With `portWide` high, lane select 11 accepts any access, and 01 or 10 accepts only an access whose `busLane` equals it (bit 0 is the lower byte, bit 1 the upper byte).
- R3: Direction select 00 never asserts, 01 accepts reads only (`busRead`=1), 10 accepts writes only, and 11 accepts both.
- R4: `busFc` uses 00 for CPU, 01 for user, 10 for supervisor and 11 for reserved. Space select 00/01/10 requires the same `busFc`, and 11 accepts user or supervisor. A CPU-space access also needs `busIack` high and an interrupt level of 000 or equal to `iackLevel`. `busHit` must be high.
- R5: A matching cycle drives `csN` low on the edge that first sees `asN` low (async, data-strobe timing 0), or sees both `asN` and `dsN` low (async, data-strobe timing 1), or sees `asN` low with `slowTick` high (sync mode, data-strobe timing ignored).
- R6: With acknowledge code W in 0..13, `ackN` is low for exactly one cycle, starting W+1 cycles after `csN` goes low.
- R7: Code 1110 drives `ackN` low on the same edge as `csN`. Code 1111 never drives `ackN` or `avecN` low.
- R8: When the autovector bit is set and the matched access is in CPU space, `avecN` pulses in place of `ackN`, with the same timing.
- R9: On the edge after `asN` is seen high, `csN`, `ackN` and `avecN` are all high.
- R10: Out of reset all outputs are high. An ordinary channel's option word is zero. A boot channel's option word is `BOOT_OPT` (default: lanes 11, both directions, address-strobe timing, 13 waits, user or supervisor).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Option word write enable |
| cfgData | input | 16 | Option word value |
| portWide | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| busHit | input | 1 | Address range hit |
| busRead | input | 1 | 1 = read, 0 = write |
| busLane | input | 2 | Accessed byte lanes |
| busFc | input | 2 | Access space code |
| busIack | input | 1 | Interrupt-acknowledge cycle |
| iackLevel | input | 3 | Level being acknowledged |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| slowTick | input | 1 | One-cycle pulse marking the slow bus clock |
| csN | output | 1 | Chip-select, active low |
| ackN | output | 1 | Internal transfer acknowledge, active low |
| avecN | output | 1 | Autovector request, active low |

## Verification
The bench targets word accesses against a single-lane select on a wide port. A decoder that ignores port width would assert there, and one that over-applies width would miss 8-bit accesses. CPU-space cycles are run with level wildcard, matching level, mismatching level and no acknowledge cycle, so a broken level compare or space fallthrough shows up as a stray or missing select. Wait counts 0, 1 and 13 are run against fast and external codes under all three strobe timings. An off-by-one counter, a doubled acknowledge pulse, an ignored data strobe, or a sync mode that still listens to the strobe bit each move the observed acknowledge or select cycle away from the model.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef struct packed {
    logic       syncMode;
    logic [1:0] laneSel;
    logic [1:0] dirSel;
    logic       dsTimed;
    logic [3:0] ackCode;
    logic [1:0] spaceSel;
    logic [2:0] irqLevel;
    logic       autoVec;
  } csOpt_t;

  localparam int OPT_W     = $bits(csOpt_t);
  localparam int CNT_W     = 4;
  localparam int MAX_WAITS = 13;

  localparam logic [CNT_W-1:0] CODE_FAST = 4'b1110;
  localparam logic [CNT_W-1:0] CODE_EXT  = 4'b1111;

  localparam logic [1:0] FC_CPU  = 2'b00;
  localparam logic [1:0] FC_USER = 2'b01;
  localparam logic [1:0] FC_SUPV = 2'b10;
  localparam logic [1:0] SP_BOTH = 2'b11;

  typedef enum logic [1:0] {
    ACK_WAIT = 2'd0,
    ACK_FAST = 2'd1,
    ACK_EXT  = 2'd2
  } ackKind_t;

  typedef struct packed {
    logic load;
    logic step;
    logic clear;
  } csCmd_t;

endpackage

// File: rtl/cs_dpath.sv
module cs_dpath
  import cs_pkg::*;
#(
  parameter bit                 IS_BOOT  = 1'b0,
  parameter logic [OPT_W-1:0]   BOOT_OPT = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [OPT_W-1:0] cfgData,
  input  logic             portWide,
  input  logic             busHit,
  input  logic             busRead,
  input  logic [1:0]       busLane,
  input  logic [1:0]       busFc,
  input  logic             busIack,
  input  logic [2:0]       iackLevel,
  input  logic             asN,
  input  logic             dsN,
  input  logic             slowTick,
  input  csCmd_t           cmd,
  output logic             matchNow,
  output logic             startNow,
  output logic             cntZero,
  output ackKind_t         kindNow,
  output logic             vecNow,
  output logic             vecHeld
);

  csOpt_t          opt;
  csOpt_t          rstOpt;
  logic [CNT_W-1:0] waitCnt;

  // reset value picked by the channel flavour
  generate
    if (IS_BOOT) begin : g_boot
      assign rstOpt = csOpt_t'(BOOT_OPT);
    end else begin : g_plain
      assign rstOpt = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      opt <= rstOpt;
    else if (cfgWe) opt <= csOpt_t'(cfgData);
  end

  // qualification terms
  logic laneOk, dirOk, spaceOk, levelOk, cpuAcc;

  always_comb begin
    cpuAcc  = (busFc == FC_CPU);
    laneOk  = (opt.laneSel != 2'b00) &&
              (!portWide || opt.laneSel == 2'b11 || busLane == opt.laneSel);
    dirOk   = busRead ? opt.dirSel[0] : opt.dirSel[1];
    if (opt.spaceSel == SP_BOTH)
      spaceOk = (busFc == FC_USER) || (busFc == FC_SUPV);
    else
      spaceOk = (busFc == opt.spaceSel);
    levelOk = !cpuAcc ||
              (busIack && (opt.irqLevel == 3'd0 || opt.irqLevel == iackLevel));
    matchNow = busHit && laneOk && dirOk && spaceOk && levelOk;
  end

  // timing source
  always_comb begin
    if (opt.syncMode)     startNow = !asN && slowTick;
    else if (opt.dsTimed) startNow = !asN && !dsN;
    else                  startNow = !asN;
  end

  always_comb begin
    if (opt.ackCode == CODE_EXT)       kindNow = ACK_EXT;
    else if (opt.ackCode == CODE_FAST) kindNow = ACK_FAST;
    else                               kindNow = ACK_WAIT;
    vecNow = opt.autoVec && cpuAcc;
  end

  // wait-state counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      vecHeld <= 1'b0;
    end else if (cmd.clear) begin
      waitCnt <= '0;
      vecHeld <= 1'b0;
    end else if (cmd.load) begin
      waitCnt <= (opt.ackCode <= CNT_W'(MAX_WAITS)) ? opt.ackCode : '0;
      vecHeld <= vecNow;
    end else if (cmd.step) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign cntZero = (waitCnt == '0);

endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     asN,
  input  logic     matchNow,
  input  logic     startNow,
  input  logic     cntZero,
  input  ackKind_t kindNow,
  input  logic     vecNow,
  input  logic     vecHeld,
  output csCmd_t   cmd,
  output logic     csN,
  output logic     ackN,
  output logic     avecN
);

  typedef enum logic {ST_IDLE = 1'b0, ST_ACTIVE = 1'b1} state_t;

  state_t state;
  logic   done;

  always_comb begin
    cmd.load  = (state == ST_IDLE) && matchNow && startNow;
    cmd.clear = (state == ST_ACTIVE) && asN;
    cmd.step  = (state == ST_ACTIVE) && !asN && !cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      csN   <= 1'b1;
      ackN  <= 1'b1;
      avecN <= 1'b1;
      done  <= 1'b0;
    end else begin
      ackN  <= 1'b1;
      avecN <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (cmd.load) begin
            state <= ST_ACTIVE;
            csN   <= 1'b0;
            done  <= (kindNow != ACK_WAIT);
            if (kindNow == ACK_FAST) begin
              if (vecNow) avecN <= 1'b0;
              else        ackN  <= 1'b0;
            end
          end
        end
        ST_ACTIVE: begin
          if (asN) begin
            state <= ST_IDLE;
            csN   <= 1'b1;
            done  <= 1'b0;
          end else if (cntZero && !done) begin
            done <= 1'b1;
            if (vecHeld) avecN <= 1'b0;
            else         ackN  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cs_channel.sv
module cs_channel
  import cs_pkg::*;
#(
  parameter bit               IS_BOOT  = 1'b0,
  parameter logic [OPT_W-1:0] BOOT_OPT = 16'h7B70
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [OPT_W-1:0] cfgData,
  input  logic             portWide,
  input  logic             busHit,
  input  logic             busRead,
  input  logic [1:0]       busLane,
  input  logic [1:0]       busFc,
  input  logic             busIack,
  input  logic [2:0]       iackLevel,
  input  logic             asN,
  input  logic             dsN,
  input  logic             slowTick,
  output logic             csN,
  output logic             ackN,
  output logic             avecN
);

  csCmd_t   cmd;
  logic     matchNow, startNow, cntZero, vecNow, vecHeld;
  ackKind_t kindNow;

  cs_dpath #(.IS_BOOT(IS_BOOT), .BOOT_OPT(BOOT_OPT)) dpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .portWide(portWide), .busHit(busHit), .busRead(busRead),
    .busLane(busLane), .busFc(busFc), .busIack(busIack),
    .iackLevel(iackLevel), .asN(asN), .dsN(dsN), .slowTick(slowTick),
    .cmd(cmd), .matchNow(matchNow), .startNow(startNow),
    .cntZero(cntZero), .kindNow(kindNow), .vecNow(vecNow),
    .vecHeld(vecHeld)
  );

  cs_ctrl ctrl (
    .clk(clk), .rstN(rstN), .asN(asN), .matchNow(matchNow),
    .startNow(startNow), .cntZero(cntZero), .kindNow(kindNow),
    .vecNow(vecNow), .vecHeld(vecHeld), .cmd(cmd),
    .csN(csN), .ackN(ackN), .avecN(avecN)
  );

endmodule

// File: rtl/cs_channel_chk.sv
module cs_channel_chk (
  input logic clk,
  input logic rstN,
  input logic asN,
  input logic csN,
  input logic ackN,
  input logic avecN
);

  // R5: select only falls on an edge that saw the address strobe low
  a_r5_cs_after_as: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !$past(asN));

  // R6: acknowledge is a single-cycle pulse
  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |=> ackN);

  // R6: acknowledge only inside an asserted select
  a_r6_ack_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> !csN);

  // R8: autovector pulse is single-cycle and never overlaps acknowledge
  a_r8_vec_single: assert property (@(posedge clk) disable iff (!rstN)
    !avecN |=> avecN);

  a_r8_vec_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!ackN && !avecN));

  // R9: negated address strobe releases everything next edge
  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    asN |=> (csN && ackN && avecN));

endmodule

bind cs_channel cs_channel_chk chk (
  .clk(clk), .rstN(rstN), .asN(asN), .csN(csN), .ackN(ackN), .avecN(avecN)
);

// File: tb/cs_channel_test.sv
`timescale 1ns/100ps
module cs_channel_test;

  localparam int DS_AT   = 1;
  localparam int TICK_AT = 3;
  localparam int HOLD    = 20;
  localparam logic [15:0] BOOT_OPT = 16'h7B70;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [15:0] cfgData = '0;
  logic portWide = 1'b1;
  logic busHit = 1'b0, busRead = 1'b1, busIack = 1'b0;
  logic [1:0] busLane = 2'b11, busFc = 2'b01;
  logic [2:0] iackLevel = '0;
  logic asN = 1'b1, dsN = 1'b1, slowTick = 1'b0;
  logic csN, ackN, avecN, bCsN, bAckN, bAvecN;

  always #2.5 clk = ~clk;

  cs_channel #(.IS_BOOT(1'b0)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .portWide(portWide), .busHit(busHit), .busRead(busRead),
    .busLane(busLane), .busFc(busFc), .busIack(busIack),
    .iackLevel(iackLevel), .asN(asN), .dsN(dsN), .slowTick(slowTick),
    .csN(csN), .ackN(ackN), .avecN(avecN));

  cs_channel #(.IS_BOOT(1'b1), .BOOT_OPT(BOOT_OPT)) bootUut (
    .clk(clk), .rstN(rstN), .cfgWe(1'b0), .cfgData(16'h0000),
    .portWide(portWide), .busHit(busHit), .busRead(busRead),
    .busLane(busLane), .busFc(busFc), .busIack(busIack),
    .iackLevel(iackLevel), .asN(asN), .dsN(dsN), .slowTick(slowTick),
    .csN(bCsN), .ackN(bAckN), .avecN(bAvecN));

  typedef struct { int csAt; int ackAt; int vecAt; } pred_t;
  typedef struct { pred_t main; pred_t boot; } item_t;

  item_t scoreQ[$];
  int checks = 0;
  int errors = 0;
  logic [15:0] optMirror = '0;
  bit allDone = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic pred_t predict(logic [15:0] o);
    pred_t p;
    bit laneOk, dirOk, spOk, lvOk;
    int trig, code;
    p.csAt = -1; p.ackAt = -1; p.vecAt = -1;
    laneOk = (o[14:13] != 0) &&
             (!portWide || o[14:13] == 2'b11 || busLane == o[14:13]);
    dirOk  = busRead ? o[11] : o[12];
    if (o[5:4] == 2'b11) spOk = (busFc == 2'b01 || busFc == 2'b10);
    else                 spOk = (busFc == o[5:4]);
    lvOk = (busFc != 2'b00) || (busIack && (o[3:1] == 0 || o[3:1] == iackLevel));
    if (!(busHit && laneOk && dirOk && spOk && lvOk)) return p;
    trig = o[15] ? TICK_AT : (o[10] ? DS_AT : 0);
    p.csAt = trig + 1;
    code = int'(o[9:6]);
    if (code == 15) return p;
    if (code == 14) begin
      if (o[0] && busFc == 2'b00) p.vecAt = p.csAt; else p.ackAt = p.csAt;
      return p;
    end
    if (o[0] && busFc == 2'b00) p.vecAt = p.csAt + code + 1;
    else                        p.ackAt = p.csAt + code + 1;
    return p;
  endfunction

  // R1: option word write
  task automatic writeOpt(logic [15:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgData = v;
    @(negedge clk);
    cfgWe = 1'b0;
    optMirror = v;
  endtask

  task automatic doCycle(bit hit, bit rd, logic [1:0] lane, logic [1:0] fc,
                         bit iack, logic [2:0] lvl);
    item_t it;
    @(negedge clk);
    busHit = hit; busRead = rd; busLane = lane; busFc = fc;
    busIack = iack; iackLevel = lvl;
    it.main = predict(optMirror);
    it.boot = predict(BOOT_OPT);
    scoreQ.push_back(it);
    asN = 1'b0;
    for (int i = 1; i <= HOLD; i++) begin
      @(negedge clk);
      if (i == DS_AT) dsN = 1'b0;
      slowTick = (i == TICK_AT);
    end
    asN = 1'b1; dsN = 1'b1; slowTick = 1'b0; busHit = 1'b0; busIack = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: observe each strobe window and compare against the queue
  initial begin
    bit inWin = 0, pendRel = 0;
    int idx = 0;
    int cs1, ack1, ackC, vec1, vecC, bCs1, bAck1;
    item_t it;
    forever begin
      @(negedge clk); #1;
      if (pendRel) begin
        pendRel = 0;
        check("R9 release csN", int'(csN), 1);
        check("R9 release ackN/avecN", int'(ackN & avecN), 1);
      end
      if (!asN) begin
        if (!inWin) begin
          inWin = 1; idx = 0;
          cs1 = -1; ack1 = -1; ackC = 0; vec1 = -1; vecC = 0;
          bCs1 = -1; bAck1 = -1;
        end else idx++;
        if (!csN && cs1 < 0) cs1 = idx;
        if (!ackN) begin if (ack1 < 0) ack1 = idx; ackC++; end
        if (!avecN) begin if (vec1 < 0) vec1 = idx; vecC++; end
        if (!bCsN && bCs1 < 0) bCs1 = idx;
        if (!bAckN && bAck1 < 0) bAck1 = idx;
      end else if (inWin) begin
        inWin = 0; pendRel = 1;
        if (scoreQ.size() == 0) begin
          check("scoreboard underflow", 1, 0);
        end else begin
          it = scoreQ.pop_front();
          check("R2/R3/R4/R5 cs cycle", cs1, it.main.csAt);
          check("R6/R7 ack cycle", ack1, it.main.ackAt);
          check("R6 ack width", ackC, it.main.ackAt >= 0 ? 1 : 0);
          check("R8 avec cycle", vec1, it.main.vecAt);
          check("R8 avec width", vecC, it.main.vecAt >= 0 ? 1 : 0);
          check("R10 boot cs cycle", bCs1, it.boot.csAt);
          check("R10 boot ack cycle", bAck1, it.boot.ackAt);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !allDone) begin
        errors++; checks++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset csN", int'(csN), 1);
    check("R10 reset ackN", int'(ackN), 1);
    check("R10 reset avecN", int'(avecN), 1);
    rstN = 1'b1;
    // R10: ordinary channel silent, boot channel active straight from reset
    portWide = 1'b1;
    doCycle(1, 1, 2'b11, 2'b01, 0, 0);

    // R1/R2/R3 sweep of lanes, directions and port width
    for (int pw = 0; pw < 2; pw++)
      for (int ln = 0; ln < 4; ln++)
        for (int rw = 0; rw < 4; rw++) begin
          portWide = pw[0];
          writeOpt({1'b0, ln[1:0], rw[1:0], 1'b0, 4'd0, 2'b11, 3'd0, 1'b0});
          for (int rd = 0; rd < 2; rd++)
            for (int al = 1; al < 4; al++)
              doCycle(1, rd[0], al[1:0], 2'b01, 0, 0);
        end
    portWide = 1'b1;

    // R4/R8 spaces, interrupt levels, autovector
    for (int sp = 0; sp < 4; sp++)
      for (int ip = 0; ip < 2; ip++)
        for (int av = 0; av < 2; av++) begin
          writeOpt({1'b0, 2'b11, 2'b11, 1'b0, 4'd1, sp[1:0],
                    (ip == 0) ? 3'd0 : 3'd3, av[0]});
          for (int fc = 0; fc < 4; fc++) begin
            doCycle(1, 1, 2'b11, fc[1:0], 1, 3'd3);
            doCycle(1, 1, 2'b11, fc[1:0], 1, 3'd5);
          end
          doCycle(1, 1, 2'b11, 2'b00, 0, 3'd3);
          doCycle(0, 1, 2'b11, 2'b01, 0, 3'd0);
        end

    // R5/R6/R7 timing sources and acknowledge codes
    for (int md = 0; md < 2; md++)
      for (int st = 0; st < 2; st++)
        for (int k = 0; k < 5; k++) begin
          logic [3:0] code;
          case (k)
            0: code = 4'd0;
            1: code = 4'd1;
            2: code = 4'd13;
            3: code = 4'b1110;
            default: code = 4'b1111;
          endcase
          writeOpt({md[0], 2'b11, 2'b11, st[0], code, 2'b11, 3'd0, 1'b0});
          doCycle(1, 0, 2'b11, 2'b10, 0, 0);
          doCycle(1, 1, 2'b01, 2'b01, 0, 0);
        end
    // R8 fast termination with autovector in CPU space
    writeOpt({1'b0, 2'b11, 2'b11, 1'b0, 4'b1110, 2'b00, 3'd0, 1'b1});
    doCycle(1, 1, 2'b11, 2'b00, 1, 3'd6);

    repeat (4) @(negedge clk);
    check("scoreboard drained", scoreQ.size(), 0);
    allDone = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule